// File: doc/BRIEF.md
# Write-Burst Termination Selector

This block chooses which on-die termination a DRAM device model presents on its data pins, cycle by cycle. It reads a 2-bit write-termination code and a 3-bit nominal-termination code from the mode fields. It watches the WRITE command strobe and the termination-enable pin, and drives a three-valued select: off (high-Z), nominal, or the write value. Resistor values and analog behaviour are outside its scope.

When the write code is nonzero, each WRITE opens a write-termination window. The window opens a programmable number of cycles after the command. It closes after the write latency plus the burst duration, which is 2 clocks for a 4-beat burst and 4 clocks for an 8-beat burst. WRITEs that arrive before the window closes stretch it, so termination does not drop back to nominal between bursts. Write-leveling mode suppresses the write value, and a low termination pin forces the output off.

Top module: `dyn_term_sel`

## Requirements
- R1: While `odt_pin` is 0, `term_sel` is 2'b00 (off), whatever the mode inputs or write activity.
- R2: While `odt_pin` is 1 and no write window is active, `term_sel` is 2'b01 (nominal) if `nom_term_code` is nonzero, and 2'b00 if it is zero. The value 2'b11 never appears.
- R3: A `wr_term_code` of 2'b00 disables dynamic switching: `term_sel` never shows 2'b10 (write), and WRITEs leave the nominal/off value unchanged.
- R4: A WRITE sampled at clock edge k with no window open puts `term_sel` at 2'b10 from edge k+`sw_in_lat` onward, when `odt_pin` is 1 and the write code is nonzero.
- R5: The window closes at edge k+`wr_lat`+L, where k is the last WRITE and L is 2 when `burst8` is 0 and 4 when `burst8` is 1. After edge k+`wr_lat`+L-1, `term_sel` is still 2'b10.
- R6: A WRITE sampled while a window is open or pending extends it. The close point moves to the new command, the open point stays at the first command, and there are no nominal cycles in between. This includes a WRITE in the window's final cycle.
- R7: While `wlvl_mode` is 1, `term_sel` never shows 2'b10. Outside any window it shows the nominal/off value.
- R8: With `nom_term_code` at zero and a nonzero write code, a WRITE still produces 2'b10 in its window, with 2'b00 before and after.
- R9: After reset no window is open, so `term_sel` shows the nominal/off value given by R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_cmd | input | 1 | WRITE command strobe, one cycle per command |
| odt_pin | input | 1 | Termination enable pin |
| wlvl_mode | input | 1 | Write-leveling mode flag |
| burst8 | input | 1 | 1: 8-beat bursts, 0: 4-beat bursts |
| wr_term_code | input | 2 | Write termination code, nonzero enables switching |
| nom_term_code | input | 3 | Nominal termination code, zero means disabled |
| sw_in_lat | input | LAT_W | Cycles from WRITE to switch-in |
| wr_lat | input | LAT_W | Write latency in cycles |
| term_sel | output | 2 | 00 off, 01 nominal, 10 write |

## Verification
Two functions can land in the same cycle: closing the window after its last write cycle, and extending it because of a new WRITE. The bench provokes this by issuing a second WRITE exactly `wr_lat`+L-1 edges after the first. The scoreboard expects write termination with no gap through the second burst's close point, and catches a design that drops to nominal for even one cycle. A further case opens the window with `sw_in_lat` at 1 and short latency, so that switch-in and back-to-back extension fall close together.

// File: rtl/dyn_term_sel.sv
module dyn_term_sel #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmd,
  input  logic             odt_pin,
  input  logic             wlvl_mode,
  input  logic             burst8,
  input  logic [1:0]       wr_term_code,
  input  logic [2:0]       nom_term_code,
  input  logic [LAT_W-1:0] sw_in_lat,
  input  logic [LAT_W-1:0] wr_lat,
  output logic [1:0]       term_sel
);
  localparam int CW = LAT_W + 1;
  localparam logic [1:0] SEL_OFF = 2'b00;
  localparam logic [1:0] SEL_NOM = 2'b01;
  localparam logic [1:0] SEL_WR  = 2'b10;

  logic          busy;
  logic [CW-1:0] s_cnt, e_cnt;
  logic [CW-1:0] end_pt;
  logic          in_win, dyn_ok;

  assign end_pt = CW'(wr_lat) + (burst8 ? CW'(4) : CW'(2));
  assign in_win = busy && (s_cnt >= CW'(sw_in_lat)) && (e_cnt < end_pt);
  assign dyn_ok = (wr_term_code != 2'b00) && !wlvl_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      s_cnt <= '0;
      e_cnt <= '0;
    end else if (wr_cmd) begin
      busy  <= 1'b1;
      e_cnt <= '0;
      s_cnt <= !busy ? '0 : (&s_cnt ? s_cnt : s_cnt + 1'b1);
    end else if (busy) begin
      if (e_cnt >= end_pt - 1'b1) busy <= 1'b0;
      e_cnt <= e_cnt + 1'b1;
      if (!(&s_cnt)) s_cnt <= s_cnt + 1'b1;
    end
  end

  always_comb begin
    if (!odt_pin)              term_sel = SEL_OFF;
    else if (in_win && dyn_ok) term_sel = SEL_WR;
    else if (nom_term_code != 3'd0) term_sel = SEL_NOM;
    else                       term_sel = SEL_OFF;
  end

  p_odt_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !odt_pin |-> term_sel == SEL_OFF);
  p_no_code3_r2: assert property (@(posedge clk) disable iff (!rst_n)
    term_sel != 2'b11);
  p_code0_nowr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_term_code == 2'b00 |-> term_sel != SEL_WR);
  p_extend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && in_win) |=> in_win);
  p_wlvl_nowr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wlvl_mode |-> term_sel != SEL_WR);
  p_idle_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_cmd) |=> !busy);
endmodule

// File: tb/dyn_term_sel_tb_top.sv
module dyn_term_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_cmd = 1'b0, odt_pin = 1'b1, wlvl_mode = 1'b0, burst8 = 1'b0;
  logic [1:0] wr_term_code = 2'b10;
  logic [2:0] nom_term_code = 3'd1;
  logic [LAT_W-1:0] sw_in_lat = 4'd3, wr_lat = 4'd5;
  logic [1:0] term_sel;

  int errors = 0, checks = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dyn_term_sel #(.LAT_W(LAT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .odt_pin(odt_pin),
    .wlvl_mode(wlvl_mode), .burst8(burst8), .wr_term_code(wr_term_code),
    .nom_term_code(nom_term_code), .sw_in_lat(sw_in_lat), .wr_lat(wr_lat),
    .term_sel(term_sel));

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (term_sel !== e) begin
        errors++;
        $display("FAIL %s: term_sel actual=%b expected=%b", t, term_sel, e);
      end
    end
  end

  function automatic logic [1:0] idle_val();
    if (!odt_pin) return 2'b00;
    return (nom_term_code != 0) ? 2'b01 : 2'b00;
  endfunction

  task automatic run_case(input int nwr, input int gap, input logic odt, input logic wl_m,
                          input logic [2:0] nomc, input logic [1:0] wrc, input logic b8,
                          input int lat, input int wl, input string tag);
    int len, endpt, kl, n;
    len = b8 ? 4 : 2;
    endpt = wl + len;
    kl = (nwr - 1) * gap;
    n = kl + endpt + 5;
    for (int i = 0; i < n; i++) begin
      int e;
      logic win;
      logic [1:0] ex;
      @(posedge clk); #1;
      if (i == 0) begin
        odt_pin = odt; wlvl_mode = wl_m; nom_term_code = nomc;
        wr_term_code = wrc; burst8 = b8;
        sw_in_lat = LAT_W'(lat); wr_lat = LAT_W'(wl);
      end
      wr_cmd = (i % gap == 0) && (i / gap < nwr);
      e = i - 1;
      win = (e >= lat) && (e < kl + endpt);
      if (!odt) ex = 2'b00;
      else if (win && wrc != 0 && !wl_m) ex = 2'b10;
      else ex = idle_val();
      exp_q.push_back(ex);
      tag_q.push_back(tag);
    end
    @(posedge clk); #1;
    wr_cmd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL all: watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (term_sel !== 2'b01) begin
      errors++;
      $display("FAIL R9: reset term_sel actual=%b expected=01", term_sel);
    end
    run_case(1, 1, 1, 0, 3'd1, 2'b10, 0, 3, 5, "R4 R5 bl4 single");
    run_case(1, 1, 1, 0, 3'd2, 2'b01, 1, 3, 5, "R5 bl8 single");
    run_case(3, 2, 1, 0, 3'd1, 2'b11, 0, 3, 5, "R6 back-to-back");
    run_case(2, 6, 1, 0, 3'd1, 2'b10, 0, 3, 5, "R6 write in final cycle");
    run_case(3, 4, 1, 0, 3'd3, 2'b10, 1, 2, 4, "R6 bl8 chain");
    run_case(1, 1, 1, 0, 3'd0, 2'b01, 1, 3, 5, "R8 nominal off");
    run_case(1, 1, 1, 0, 3'd2, 2'b00, 1, 3, 5, "R3 code zero");
    run_case(1, 1, 1, 1, 3'd1, 2'b10, 0, 3, 5, "R7 write leveling");
    run_case(2, 3, 0, 0, 3'd1, 2'b10, 1, 3, 5, "R1 odt low");
    run_case(2, 1, 1, 0, 3'd1, 2'b10, 0, 1, 2, "R4 short latency");
    run_case(1, 1, 1, 0, 3'd0, 2'b00, 0, 3, 5, "R2 all off");
    @(posedge clk); @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule